// File: doc/BRIEF.md
# Trace Stream Trigger Controller

This block decides, on every clock, which of three trace streams (program counter, timing, data) are capturing. Trigger inputs arrive from an event unit, and each one carries a 3-bit stream mask. The triggers mix four kinds of behaviour. Start and end triggers latch or clear an enable. Store-sample triggers act only while their condition holds. Suspend triggers inhibit capture for as long as they are held. End-all clears every stream. A one-shot marker pulse and a persistent trace-on mode complete the set.

A small register file holds an inclusive program-counter window and an inclusive data-address window. Each window drives its own level trigger onto a configurable set of streams. The program-counter window can be inverted so that it excludes addresses instead of including them. The data-address window captures every data sample in any cycle in which the address lies inside it. Mask bit 0 is the program-counter stream, bit 1 is the timing stream and bit 2 is the data stream. `cap_active` and `marker` are registered, so they reflect the inputs of the previous clock cycle.

Top module: `trace_trigger_ctrl`

## Requirements
- R1: When `start_trig` is high, the streams in `start_mask` latch on and show in `cap_active` one cycle later. They stay on after the trigger drops. A start on a stream that is already on changes nothing.
- R2: When `end_trig` is high, only the streams in `end_mask` are cleared. An end on a stream that is already off changes nothing. If a start and an end name the same stream in the same cycle, the end wins.
- R3: When `store_trig` is high, the streams in `store_mask` are active in the next cycle only. Nothing is latched.
- R4: When `susp_trig` is high, the streams in `susp_mask` are forced inactive in the next cycle. The latched enables are kept, so capture resumes after the suspend drops without a new start.
- R5: A `mark_trig` while the marker is armed gives a one-cycle `marker` pulse and disarms the marker. Further `mark_trig` pulses have no effect until `mark_clr` re-arms it. The marker is armed out of reset.
- R6: `end_all` clears every latched enable and every persistent enable. It forces `cap_active` to 0 in the next cycle, overriding any start, store, window or configuration input in the same cycle.
- R7: A configuration write to select 5 sets persistent enables for the streams in data bits [2:0]. An ordinary end trigger does not clear them; only `end_all` does.
- R8: Select 0 is the low program-counter bound and select 1 is the high bound. Select 4 holds the window's stream mask in bits [2:0]. With `pc_vld` high and low ≤ `pc` ≤ high (both bounds inclusive), the window's streams are active in the next cycle.
- R9: When select 4 bit 3 is set, the program-counter window is inverted. Its streams are active only when `pc_vld` is high and `pc` lies outside the bounds.
- R10: Select 2 is the low data-address bound and select 3 is the high bound. The window's stream mask is in select 4 bits [6:4]. With `da_vld` high and `da` inside the bounds (inclusive), those streams are active in the next cycle.
- R11: After reset, `cap_active` and `marker` are 0, all enables are off, all configuration registers are 0 and the marker is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| pc | input | AW | Program counter |
| pc_vld | input | 1 | Program counter valid |
| da | input | AW | Data address |
| da_vld | input | 1 | Data access valid |
| start_trig | input | 1 | Start trigger |
| start_mask | input | 3 | Streams for start |
| end_trig | input | 1 | End trigger |
| end_mask | input | 3 | Streams for end |
| susp_trig | input | 1 | Suspend condition (level) |
| susp_mask | input | 3 | Streams for suspend |
| store_trig | input | 1 | Store-sample condition (level) |
| store_mask | input | 3 | Streams for store-sample |
| mark_trig | input | 1 | Marker trigger |
| mark_clr | input | 1 | Marker re-arm |
| end_all | input | 1 | Clear all streams |
| cap_active | output | 3 | Per-stream capture active |
| marker | output | 1 | One-shot marker pulse |

## Verification
The hardest situations to reach are those where several trigger kinds collide in one cycle. Examples are end-all against a persistent enable, a pending start and an open window, or a suspend overlapping both a latched stream and a store-sample on the same stream. Directed phases first step through each rule in isolation, including the window boundary addresses on both sides. A long random phase then drives every trigger with low-density pulses, so that collisions happen often, while a behavioural model is compared every cycle.

// File: rtl/trace_trigger_ctrl.sv
module trace_trigger_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [AW-1:0] pc,
  input  logic          pc_vld,
  input  logic [AW-1:0] da,
  input  logic          da_vld,
  input  logic          start_trig,
  input  logic [2:0]    start_mask,
  input  logic          end_trig,
  input  logic [2:0]    end_mask,
  input  logic          susp_trig,
  input  logic [2:0]    susp_mask,
  input  logic          store_trig,
  input  logic [2:0]    store_mask,
  input  logic          mark_trig,
  input  logic          mark_clr,
  input  logic          end_all,
  output logic [2:0]    cap_active,
  output logic          marker
);

  localparam int NS = 3;

  logic [AW-1:0] pc_lo, pc_hi, da_lo, da_hi;
  logic [NS-1:0] pcw_mask, daw_mask;
  logic          pcw_inv;
  logic [NS-1:0] lat_en, pin_en;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_lo    <= '0;
      pc_hi    <= '0;
      da_lo    <= '0;
      da_hi    <= '0;
      pcw_mask <= '0;
      pcw_inv  <= 1'b0;
      daw_mask <= '0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        3'd0: pc_lo <= cfg_wdata;
        3'd1: pc_hi <= cfg_wdata;
        3'd2: da_lo <= cfg_wdata;
        3'd3: da_hi <= cfg_wdata;
        3'd4: begin
          pcw_mask <= cfg_wdata[2:0];
          pcw_inv  <= cfg_wdata[3];
          daw_mask <= cfg_wdata[6:4];
        end
        default: ;
      endcase
    end
  end

  wire pc_in  = pc_vld && (pc >= pc_lo) && (pc <= pc_hi);
  wire pc_hit = pcw_inv ? (pc_vld && !pc_in) : pc_in;
  wire da_hit = da_vld && (da >= da_lo) && (da <= da_hi);

  wire [NS-1:0] set_m  = start_trig ? start_mask : '0;
  wire [NS-1:0] clr_m  = end_trig   ? end_mask   : '0;
  wire [NS-1:0] gate_m = susp_trig  ? susp_mask  : '0;
  wire [NS-1:0] pin_m  = (cfg_wr && cfg_sel == 3'd5) ? cfg_wdata[2:0] : '0;
  wire [NS-1:0] lvl_m  = (store_trig ? store_mask : '0)
                       | (pc_hit ? pcw_mask : '0)
                       | (da_hit ? daw_mask : '0);

  wire [NS-1:0] lat_nx = (lat_en | set_m) & ~clr_m;
  wire [NS-1:0] pin_nx = pin_en | pin_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_en     <= '0;
      pin_en     <= '0;
      cap_active <= '0;
    end else if (end_all) begin
      lat_en     <= '0;
      pin_en     <= '0;
      cap_active <= '0;
    end else begin
      lat_en     <= lat_nx;
      pin_en     <= pin_nx;
      cap_active <= (lat_nx | pin_nx | lvl_m) & ~gate_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b1;
      marker <= 1'b0;
    end else begin
      marker <= mark_trig && armed;
      armed  <= mark_clr || (armed && !mark_trig);
    end
  end

endmodule

// File: rtl/trace_trigger_ctrl_chk.sv
module trace_trigger_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_trig,
  input logic [2:0] start_mask,
  input logic       end_trig,
  input logic       susp_trig,
  input logic [2:0] susp_mask,
  input logic       store_trig,
  input logic [2:0] store_mask,
  input logic       mark_clr,
  input logic       end_all,
  input logic [2:0] cap_active,
  input logic       marker
);

  // R6
  endall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_all |=> cap_active == 3'b000);

  // R4
  susp_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_trig |=> (cap_active & $past(susp_mask)) == 3'b000);

  // R3
  store_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_trig && !susp_trig && !end_all) |=>
      (cap_active & $past(store_mask)) == $past(store_mask));

  // R1
  start_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_trig && !end_trig && !susp_trig && !end_all) |=>
      (cap_active & $past(start_mask)) == $past(start_mask));

  // R5
  marker_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (marker && !$past(mark_clr)) |=> !marker);

endmodule

bind trace_trigger_ctrl trace_trigger_ctrl_chk u_chk (.*);

// File: tb/tb_trace_trigger_ctrl.sv
module tb_trace_trigger_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0; logic [2:0] cfg_sel = 0; logic [AW-1:0] cfg_wdata = 0;
  logic [AW-1:0] pc = 0, da = 0; logic pc_vld = 0, da_vld = 0;
  logic start_trig = 0, end_trig = 0, susp_trig = 0, store_trig = 0;
  logic [2:0] start_mask = 0, end_mask = 0, susp_mask = 0, store_mask = 0;
  logic mark_trig = 0, mark_clr = 0, end_all = 0;
  logic [2:0] cap_active; logic marker;

  trace_trigger_ctrl #(.AW(AW)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R11";
  bit done = 0;

  // behavioural reference
  longint unsigned r_plo, r_phi, r_dlo, r_dhi;
  int r_pmask, r_dmask, r_inv;
  bit r_en[3], r_on[3];
  bit r_armed;
  int r_cap; bit r_mark;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_plo = 0; r_phi = 0; r_dlo = 0; r_dhi = 0;
      r_pmask = 0; r_dmask = 0; r_inv = 0;
      for (int s = 0; s < 3; s++) begin r_en[s] = 0; r_on[s] = 0; end
      r_armed = 1; r_cap = 0; r_mark = 0;
    end else begin
      bit inwin, pwin, dwin;
      int cap;
      inwin = pc_vld && (pc >= r_plo) && (pc <= r_phi);
      pwin = (r_inv != 0) ? (pc_vld && !inwin) : inwin;
      dwin = da_vld && (da >= r_dlo) && (da <= r_dhi);
      cap = 0;
      for (int s = 0; s < 3; s++) begin
        bit act;
        if (end_all) begin
          r_en[s] = 0; r_on[s] = 0;
        end else begin
          if (end_trig && end_mask[s]) r_en[s] = 0;
          else if (start_trig && start_mask[s]) r_en[s] = 1;
          if (cfg_wr && cfg_sel == 5 && cfg_wdata[s]) r_on[s] = 1;
        end
        act = r_en[s] || r_on[s] || (store_trig && store_mask[s])
              || (pwin && r_pmask[s]) || (dwin && r_dmask[s]);
        if (susp_trig && susp_mask[s]) act = 0;
        if (end_all) act = 0;
        if (act) cap += (1 << s);
      end
      r_cap = cap;
      r_mark = mark_trig && r_armed;
      if (mark_clr) r_armed = 1; else if (mark_trig) r_armed = 0;
      if (cfg_wr) begin
        case (cfg_sel)
          0: r_plo = cfg_wdata;
          1: r_phi = cfg_wdata;
          2: r_dlo = cfg_wdata;
          3: r_dhi = cfg_wdata;
          4: begin r_pmask = cfg_wdata & 7; r_inv = cfg_wdata[3]; r_dmask = (cfg_wdata >> 4) & 7; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (cap_active !== r_cap[2:0] || marker !== r_mark) begin
      fails++;
      $display("FAIL %s t=%0t cap_active=%b marker=%b expected cap_active=%b marker=%b",
               tag, $time, cap_active, marker, r_cap[2:0], r_mark);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(input int sel, input logic [AW-1:0] d);
    cfg_wr = 1; cfg_sel = sel[2:0]; cfg_wdata = d; tick(); cfg_wr = 0;
  endtask

  task automatic clear_ins();
    start_trig = 0; end_trig = 0; susp_trig = 0; store_trig = 0;
    mark_trig = 0; mark_clr = 0; end_all = 0; pc_vld = 0; da_vld = 0; cfg_wr = 0;
  endtask

  initial begin
    tag = "R11"; tick(3); rst_n = 1; tick(2);

    tag = "R1";
    start_trig = 1; start_mask = 3'b011; tick(); start_trig = 0; tick(3);
    start_trig = 1; start_mask = 3'b001; tick(); start_trig = 0; tick(2);

    tag = "R2";
    end_trig = 1; end_mask = 3'b001; tick(); end_trig = 0; tick(2);
    end_trig = 1; end_mask = 3'b100; tick(); end_trig = 0; tick(2);
    start_trig = 1; start_mask = 3'b101; end_trig = 1; end_mask = 3'b100; tick();
    clear_ins(); tick(2);
    end_trig = 1; end_mask = 3'b111; tick(); end_trig = 0; tick();

    tag = "R3";
    store_trig = 1; store_mask = 3'b100; tick(2); store_trig = 0; tick(2);

    tag = "R4";
    start_trig = 1; start_mask = 3'b111; tick(); start_trig = 0; tick();
    susp_trig = 1; susp_mask = 3'b001; tick(3); susp_trig = 0; tick(2);
    susp_trig = 1; susp_mask = 3'b100; store_trig = 1; store_mask = 3'b100; tick();
    clear_ins(); tick(2);

    tag = "R5";
    mark_trig = 1; tick(); mark_trig = 0; tick();
    mark_trig = 1; tick(); mark_trig = 0; tick(2);
    mark_clr = 1; tick(); mark_clr = 0; mark_trig = 1; tick(); mark_trig = 0; tick(2);

    tag = "R6";
    end_all = 1; start_trig = 1; start_mask = 3'b111; store_trig = 1; store_mask = 3'b010; tick();
    clear_ins(); tick(2);

    tag = "R7";
    wcfg(5, 3'b010); tick();
    end_trig = 1; end_mask = 3'b111; tick(); end_trig = 0; tick(2);
    end_all = 1; tick(); end_all = 0; tick(2);

    tag = "R8";
    wcfg(0, 32'h100); wcfg(1, 32'h1FF); wcfg(4, 32'h001);
    pc_vld = 1;
    pc = 32'h0FF; tick(); pc = 32'h100; tick(); pc = 32'h150; tick();
    pc = 32'h1FF; tick(); pc = 32'h200; tick(); pc_vld = 0; pc = 32'h150; tick(2);

    tag = "R9";
    wcfg(4, 32'h00B);
    pc_vld = 1;
    pc = 32'h0FF; tick(); pc = 32'h100; tick(); pc = 32'h1FF; tick(); pc = 32'h200; tick();
    pc_vld = 0; pc = 32'h300; tick(2);

    tag = "R10";
    wcfg(4, 32'h040); wcfg(2, 32'h800000); wcfg(3, 32'h800010);
    da_vld = 1;
    da = 32'h7FFFFF; tick(); da = 32'h800000; tick(); da = 32'h800010; tick();
    da = 32'h800011; tick(); da_vld = 0; da = 32'h800004; tick(2);

    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      start_trig = (r % 5) == 0; start_mask = $urandom;
      end_trig   = (r % 7) == 0; end_mask = $urandom;
      susp_trig  = (r % 6) == 0; susp_mask = $urandom;
      store_trig = (r % 4) == 0; store_mask = $urandom;
      mark_trig  = (r % 9) == 0; mark_clr = (r % 13) == 0;
      end_all    = (r % 23) == 0;
      cfg_wr     = (r % 17) == 0; cfg_sel = $urandom_range(0, 5);
      cfg_wdata  = (cfg_sel < 4) ? 32'h100 + $urandom_range(0, 64) : $urandom & 32'h7F;
      pc_vld = $urandom; pc = 32'h100 + $urandom_range(0, 64);
      da_vld = $urandom; da = 32'h100 + $urandom_range(0, 64);
      tick();
    end
    clear_ins(); tick(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired in %s", tag);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule